// File: doc/BRIEF.md
# Line Clock Activity Monitor

This block watches sixteen line clocks, a transmit clock and a receive clock for each of eight channel groups. Every clock is brought into the system clock domain and its rising edges are counted. A sticky activity flag is raised once a clock has shown two rising edges since the flag was last cleared. Software reads all sixteen flags through one 32-bit status word. Every read clears the flags.

The block also sits between a host and the private RAMs of the channel groups. A per-clock watchdog decides whether each transmit clock is present. While a group's transmit clock is absent, host reads of that group's RAM return a fixed marker word and never reach the RAM, and host writes are dropped. While the clock is present, accesses pass through unchanged. The read response always arrives exactly one cycle after the request.

The host port has no back-pressure. A request is accepted in any cycle where `host_req` is high. A read response is a single-cycle `host_rsp_valid` pulse that cannot be stalled. The status read strobe and the reset inputs are plain level or pulse controls.

Top module: `lclk_activity_mon`

## Requirements
- R1: Status bit layout. Transmit flags of groups 7..4 sit at bits 31..28 and receive flags of groups 7..4 at bits 27..24. Transmit flags of groups 3..0 sit at bits 23..20 and receive flags of groups 3..0 at bits 19..16. Bits 15..0 always read 0.
- R2: A clear flag is set by the second synchronized rising edge of its line clock, counted from the last clear. A single edge leaves it at 0.
- R3: A cycle with `stat_rd` high presents the current flags on `stat_word`. From the next cycle all flags and their edge counts are 0.
- R4: `rst_n` low, or `soft_chip_rst` high for one cycle, clears all flags. `soft_grp_rst[g]` clears only the transmit and receive flags of group g.
- R5: A line clock that does not toggle leaves its flag at 0, whatever the other clocks do.
- R6: A host read (`host_req`=1, `host_we`=0) to a group whose transmit clock is absent keeps `ram_en` low. One cycle later it returns `host_rdata` = 0xDEADACCE with `host_rsp_valid` high.
- R7: A host write to a group whose transmit clock is absent keeps `ram_en` low, so the RAM contents are unchanged.
- R8: A transmit clock is absent after reset and becomes present on its first synchronized edge. It becomes absent again after ABSENT_CYC system cycles with no edge. A present group's access is forwarded to the RAM in the same cycle, and read data is returned one cycle later.
- R9: If a status read and a qualifying second edge fall in the same cycle, the flag is 1 after that cycle.
- R10: Only the transmit clock decides RAM access. Activity on a group's receive clock alone leaves the group's RAM inaccessible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Chip reset, asynchronous, active low |
| soft_chip_rst | input | 1 | Synchronous clear of all flags |
| soft_grp_rst | input | 8 | Synchronous clear of one group's two flags, one bit per group |
| lclk_tx | input | 8 | Raw transmit line clocks, one per group |
| lclk_rx | input | 8 | Raw receive line clocks, one per group |
| stat_rd | input | 1 | Status word read strobe (clear on read) |
| stat_word | output | 32 | Packed activity flags |
| host_req | input | 1 | Host RAM access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_grp | input | 3 | Target channel group |
| host_addr | input | AW | Word address inside the group RAM |
| host_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | Read response valid, one cycle after the read |
| host_rdata | output | 32 | Read data or dead-access marker |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_grp | output | 3 | RAM group select |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after `ram_en` |

## Verification
The assertions check on every cycle the properties that can be stated locally. Accesses to a group with no transmit clock never reach the RAM. Dead reads come back as the marker word one cycle later, and every read produces a response exactly one cycle later. A status read with no coincident qualifying edge leaves the word at 0, while a coincident edge leaves it non-zero. A soft chip reset empties the word.

The bench scenarios show what depends on edge history and layout. They show that exactly the second edge of each of the sixteen clocks sets exactly its own bit position, and that group resets clear only their two bits. They also show that the watchdog declares a clock absent after the idle window and present again on the next edge, and that receive activity alone never opens the RAM.

// File: rtl/lclk_mon_pkg.sv
package lclk_mon_pkg;
  localparam int unsigned NGRP  = 8;
  localparam int unsigned NLANE = 2 * NGRP;
  localparam int unsigned GW    = $clog2(NGRP);
  localparam logic [31:0] DEAD_WORD = 32'hDEADACCE;

  // Position of a flag in the status word: upper half of groups first.
  function automatic logic [4:0] stat_bit(input logic is_rx, input int unsigned grp);
    int unsigned base;
    if (grp >= NGRP / 2) base = (is_rx ? 24 : 28) + grp - NGRP / 2;
    else                 base = (is_rx ? 16 : 20) + grp;
    return 5'(base);
  endfunction
endpackage

// File: rtl/lclk_lane.sv
module lclk_lane #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic rd_clr,
  input  logic lclk,
  output logic rise,
  output logic act_set,
  output logic flag
);
  logic [SYNC:0] sh;
  logic [1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], lclk};
  end

  assign rise    = sh[SYNC-1] & ~sh[SYNC];
  assign act_set = rise & (cnt == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (soft_clr) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (rd_clr) begin
      cnt  <= act_set ? 2'd2 : 2'd0;
      flag <= act_set;
    end else begin
      if (rise && cnt != 2'd2) cnt <= cnt + 2'd1;
      if (act_set) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/lclk_watch.sv
module lclk_watch #(
  parameter int unsigned ABSENT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic present
);
  localparam int unsigned CW = $clog2(ABSENT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(ABSENT_CYC - 1);
  logic [CW-1:0] idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle    <= '0;
      present <= 1'b0;
    end else if (rise) begin
      idle    <= '0;
      present <= 1'b1;
    end else if (present) begin
      if (idle == LAST) begin
        present <= 1'b0;
        idle    <= '0;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lclk_ram_gate.sv
module lclk_ram_gate
  import lclk_mon_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] present,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [GW-1:0]   host_grp,
  input  logic [AW-1:0]   host_addr,
  input  logic [31:0]     host_wdata,
  output logic            host_rsp_valid,
  output logic [31:0]     host_rdata,
  output logic            ram_en,
  output logic            ram_we,
  output logic [GW-1:0]   ram_grp,
  output logic [AW-1:0]   ram_addr,
  output logic [31:0]     ram_wdata,
  input  logic [31:0]     ram_rdata
);
  logic open_q;
  logic rsp_q;
  logic dead_q;

  assign open_q    = present[host_grp];
  assign ram_en    = host_req & open_q;
  assign ram_we    = host_we;
  assign ram_grp   = host_grp;
  assign ram_addr  = host_addr;
  assign ram_wdata = host_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q  <= 1'b0;
      dead_q <= 1'b0;
    end else begin
      rsp_q  <= host_req & ~host_we;
      dead_q <= ~open_q;
    end
  end

  assign host_rsp_valid = rsp_q;
  assign host_rdata     = dead_q ? DEAD_WORD : ram_rdata;
endmodule

// File: rtl/lclk_activity_mon.sv
module lclk_activity_mon
  import lclk_mon_pkg::*;
#(
  parameter int unsigned AW         = 10,
  parameter int unsigned ABSENT_CYC = 1024,
  parameter int unsigned SYNC       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_chip_rst,
  input  logic [NGRP-1:0] soft_grp_rst,
  input  logic [NGRP-1:0] lclk_tx,
  input  logic [NGRP-1:0] lclk_rx,
  input  logic            stat_rd,
  output logic [31:0]     stat_word,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [GW-1:0]   host_grp,
  input  logic [AW-1:0]   host_addr,
  input  logic [31:0]     host_wdata,
  output logic            host_rsp_valid,
  output logic [31:0]     host_rdata,
  output logic            ram_en,
  output logic            ram_we,
  output logic [GW-1:0]   ram_grp,
  output logic [AW-1:0]   ram_addr,
  output logic [31:0]     ram_wdata,
  input  logic [31:0]     ram_rdata
);
  logic [NLANE-1:0] lclk_all;
  logic [NLANE-1:0] rise;
  logic [NLANE-1:0] act_set;
  logic [NLANE-1:0] flag;
  logic [NGRP-1:0]  tx_present;

  assign lclk_all = {lclk_rx, lclk_tx};
  assign stat_word[15:0] = '0;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int unsigned GRP = i % NGRP;
    localparam logic        RX  = (i >= NGRP);

    lclk_lane #(.SYNC(SYNC)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_clr(soft_chip_rst | soft_grp_rst[GRP]),
      .rd_clr  (stat_rd),
      .lclk    (lclk_all[i]),
      .rise    (rise[i]),
      .act_set (act_set[i]),
      .flag    (flag[i])
    );

    assign stat_word[stat_bit(RX, GRP)] = flag[i];

    if (!RX) begin : g_watch
      lclk_watch #(.ABSENT_CYC(ABSENT_CYC)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise[i]),
        .present(tx_present[GRP])
      );
    end
  end

  lclk_ram_gate #(.AW(AW)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .present       (tx_present),
    .host_req      (host_req),
    .host_we       (host_we),
    .host_grp      (host_grp),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rsp_valid(host_rsp_valid),
    .host_rdata    (host_rdata),
    .ram_en        (ram_en),
    .ram_we        (ram_we),
    .ram_grp       (ram_grp),
    .ram_addr      (ram_addr),
    .ram_wdata     (ram_wdata),
    .ram_rdata     (ram_rdata)
  );
endmodule

// File: rtl/lclk_activity_chk.sv
module lclk_activity_chk
  import lclk_mon_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            soft_chip_rst,
  input logic            stat_rd,
  input logic [31:0]     stat_word,
  input logic            host_req,
  input logic            host_we,
  input logic [GW-1:0]   host_grp,
  input logic            host_rsp_valid,
  input logic [31:0]     host_rdata,
  input logic            ram_en,
  input logic [NGRP-1:0] tx_present,
  input logic [NLANE-1:0] act_set
);
  p_blocked_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !tx_present[host_grp]) |-> !ram_en);

  p_dead_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && !tx_present[host_grp]) |=>
      (host_rsp_valid && host_rdata == DEAD_WORD));

  p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rsp_valid);

  p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rsp_valid);

  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !soft_chip_rst && act_set == '0) |=> (stat_word == 32'h0));

  p_read_keeps_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !soft_chip_rst && act_set != '0) |=> (stat_word != 32'h0));

  p_soft_chip_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_chip_rst |=> (stat_word == 32'h0));
endmodule

bind lclk_activity_mon lclk_activity_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_chip_rst (soft_chip_rst),
  .stat_rd       (stat_rd),
  .stat_word     (stat_word),
  .host_req      (host_req),
  .host_we       (host_we),
  .host_grp      (host_grp),
  .host_rsp_valid(host_rsp_valid),
  .host_rdata    (host_rdata),
  .ram_en        (ram_en),
  .tx_present    (tx_present),
  .act_set       (act_set)
);

// File: tb/test_lclk_activity_mon.sv
module test_lclk_activity_mon;
  localparam int unsigned AW = 4;
  localparam int unsigned ABS = 32;
  localparam logic [31:0] DEAD = 32'hDEADACCE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_chip_rst = 1'b0;
  logic [7:0] soft_grp_rst = '0;
  logic [7:0] lclk_tx = '0;
  logic [7:0] lclk_rx = '0;
  logic stat_rd = 1'b0;
  logic [31:0] stat_word;
  logic host_req = 1'b0;
  logic host_we = 1'b0;
  logic [2:0] host_grp = '0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_rsp_valid;
  logic [31:0] host_rdata;
  logic ram_en, ram_we;
  logic [2:0] ram_grp;
  logic [AW-1:0] ram_addr;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lclk_activity_mon #(.AW(AW), .ABSENT_CYC(ABS)) i_lclk_activity_mon (
    .clk(clk), .rst_n(rst_n), .soft_chip_rst(soft_chip_rst),
    .soft_grp_rst(soft_grp_rst), .lclk_tx(lclk_tx), .lclk_rx(lclk_rx),
    .stat_rd(stat_rd), .stat_word(stat_word), .host_req(host_req),
    .host_we(host_we), .host_grp(host_grp), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rsp_valid(host_rsp_valid),
    .host_rdata(host_rdata), .ram_en(ram_en), .ram_we(ram_we),
    .ram_grp(ram_grp), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  // RAM model: one-cycle read latency, pattern loaded during reset.
  logic [31:0] mem [8][1<<AW];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 8; g++)
        for (int a = 0; a < (1<<AW); a++)
          mem[g][a] <= 32'hA500_0000 | (g << 8) | a;
    end else if (ram_en) begin
      if (ram_we) mem[ram_grp][ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_grp][ram_addr];
    end
  end

  function automatic int bitpos(input int lane);
    int g = lane % 8;
    bit rx = (lane >= 8);
    if (g >= 4) return (rx ? 24 : 28) + g - 4;
    return (rx ? 16 : 20) + g;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic pulse_mask(input logic [15:0] m);
    @(negedge clk);
    lclk_tx = lclk_tx | m[7:0];
    lclk_rx = lclk_rx | m[15:8];
    repeat (4) @(negedge clk);
    lclk_tx = lclk_tx & ~m[7:0];
    lclk_rx = lclk_rx & ~m[15:8];
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_stat(output logic [31:0] w);
    @(negedge clk);
    stat_rd = 1'b1;
    #1 w = stat_word;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic host_rd(input int g, input int a, output logic en, output logic v, output logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_grp = 3'(g); host_addr = AW'(a);
    #1 en = ram_en;
    @(negedge clk);
    host_req = 1'b0;
    #1 v = host_rsp_valid; d = host_rdata;
  endtask

  task automatic host_wr(input int g, input int a, input logic [31:0] d, output logic en);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_grp = 3'(g); host_addr = AW'(a); host_wdata = d;
    #1 en = ram_en;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, exp;
    logic en, v;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk(stat_word == 0, "R4 reset state", stat_word, 0);

    // R1/R2/R5: sweep all sixteen clocks
    for (int i = 0; i < 16; i++) begin
      rd_stat(w);
      pulse_mask(16'(1 << i));
      chk(stat_word == 0, "R2 single edge", stat_word, 0);
      pulse_mask(16'(1 << i));
      exp = 32'(1) << bitpos(i);
      chk(stat_word == exp, "R1 R5 second edge position", stat_word, exp);
      rd_stat(w);
      chk(w == exp, "R3 read returns flags", w, exp);
      #1 chk(stat_word == 0, "R3 cleared after read", stat_word, 0);
      pulse_mask(16'(1 << i));
      chk(stat_word == 0, "R3 count restarts after read", stat_word, 0);
    end

    // R9: read clear coinciding with a second edge
    rd_stat(w);
    pulse_mask(16'h0004);
    @(negedge clk); lclk_tx[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    #1 chk(stat_word == (32'(1) << bitpos(2)), "R9 coincident set wins", stat_word, 32'(1) << bitpos(2));
    @(negedge clk); lclk_tx[2] = 1'b0;
    repeat (4) @(negedge clk);

    // R4: group resets, soft chip reset, chip reset
    rd_stat(w);
    pulse_mask(16'hFFFF); pulse_mask(16'hFFFF);
    exp = 32'hFFFF_0000;
    chk(stat_word == exp, "R1 all flags", stat_word, exp);
    for (int g = 0; g < 8; g++) begin
      @(negedge clk); soft_grp_rst = 8'(1 << g);
      @(negedge clk); soft_grp_rst = '0;
      exp = exp & ~((32'(1) << bitpos(g)) | (32'(1) << bitpos(g + 8)));
      #1 chk(stat_word == exp, "R4 group reset", stat_word, exp);
    end
    pulse_mask(16'hFFFF); pulse_mask(16'hFFFF);
    @(negedge clk); soft_chip_rst = 1'b1;
    @(negedge clk); soft_chip_rst = 1'b0;
    #1 chk(stat_word == 0, "R4 soft chip reset", stat_word, 0);
    pulse_mask(16'hFFFF); pulse_mask(16'hFFFF);
    do_reset();
    #1 chk(stat_word == 0, "R4 chip reset", stat_word, 0);

    // R6/R7/R8/R10: RAM gating
    host_rd(3, 5, en, v, d);
    chk(!en, "R6 no RAM access when absent", 32'(en), 0);
    chk(v && d == DEAD, "R6 dead marker", d, DEAD);
    host_wr(3, 5, 32'h1234_5678, en);
    chk(!en, "R7 write dropped", 32'(en), 0);
    pulse_mask(16'h0008);
    host_rd(3, 5, en, v, d);
    exp = 32'hA500_0305;
    chk(en && v && d == exp, "R7 R8 original contents", d, exp);
    host_wr(3, 6, 32'hCAFE_0006, en);
    chk(en, "R8 write forwarded", 32'(en), 1);
    host_rd(3, 6, en, v, d);
    chk(v && d == 32'hCAFE_0006, "R8 read back", d, 32'hCAFE_0006);
    pulse_mask(16'h2000);
    host_rd(5, 1, en, v, d);
    chk(!en && d == DEAD, "R10 rx activity alone", d, DEAD);
    repeat (ABS + 8) @(negedge clk);
    host_rd(3, 6, en, v, d);
    chk(!en && d == DEAD, "R8 watchdog absent", d, DEAD);
    pulse_mask(16'h0008);
    host_rd(3, 6, en, v, d);
    chk(en && d == 32'hCAFE_0006, "R8 present again", d, 32'hCAFE_0006);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule